// File: doc/BRIEF.md
# Event Bank Scheduler

This block schedules a ring of sampling banks for one waveform-digitizer channel. At any moment one bank is recording. The other banks may be holding a frozen event, waiting for the converter, being converted, holding converted data, or being read out. A trigger can come from the channel's own discriminator or from an external input. A trigger does not stop the recording bank at once. It marks a freeze, and the freeze takes effect on the next end-of-window strobe. Several triggers before that strobe produce one freeze.

Frozen banks are handed to the converter together in one pass as soon as it is idle. Converted banks are handed to readout one at a time, in the order in which they were frozen. A bank becomes free only once readout reports it done. Capture then moves on to the next free bank in round-robin order. Dead time appears only when every bank holds an event. During that time the block raises `busy` and counts the triggers it drops. The sampling cells, the converter and the readout logic sit outside this block and are seen only through strobes and handshakes.

Top module: `evt_bank_sched`

## Requirements
- R1: After reset, bank 0 is sampling, every other bank is free, `captureBank` is 0, `busy` is 0, `dropCount` is 0, and neither start strobe is high.
- R2: Bank states are reported 3 bits per bank, with bank i at bits [3i+2:3i]. The codes are 0 free, 1 sampling, 2 frozen, 3 converting, 4 converted and 5 extracting. A trigger changes no state by itself. The sampling bank becomes frozen on a cycle that has `windowEnd` high and a trigger either pending or present in that same cycle. A `windowEnd` with no trigger leaves capture untouched.
- R3: Any number of triggers from either source, arriving before the window ends, produce exactly one freeze.
- R4: When a bank freezes, capture moves to the first free bank found from `captureBank`+1 upward, wrapping modulo the bank count. Whenever `busy` is low, exactly one bank is sampling, and it is the one named by `captureBank`.
- R5: While the converter is idle and at least one bank is frozen, `convStart` is high for one cycle. `convMask` shows every frozen bank, and all of those banks read 3 on the next cycle.
- R6: `convDone` while a conversion is active moves every converting bank to state 4. `convDone` while no conversion is active has no effect.
- R7: Banks leave state 4 for readout strictly in freeze order, one at a time. `extStart` is high for one cycle with `extBank` naming the bank, and that bank reads 5 on the next cycle.
- R8: `extDone` while a readout is active frees the extracting bank. `extDone` while no readout is active has no effect.
- R9: A freeze that finds no free bank raises `busy`, and no bank samples while it is high. A trigger that arrives while `busy` is high is dropped and adds one to `dropCount`, which saturates. `busy` clears on the cycle in which a freed bank is taken for capture.
- R10: With no conversion or readout completing, `busy` stays low through the first seven freezes and rises on the eighth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| selfTrig | input | 1 | Trigger from the channel discriminator |
| extTrig | input | 1 | Trigger from outside the channel |
| windowEnd | input | 1 | End of the current sampling window |
| convDone | input | 1 | Converter reports that its pass has finished |
| extDone | input | 1 | Readout reports that the current bank has been drained |
| captureBank | output | 3 | Index of the bank that is recording or was last frozen |
| bankState | output | 24 | Per-bank state codes, 3 bits per bank |
| convStart | output | 1 | Start a conversion pass |
| convMask | output | 8 | Banks that belong to the pass being started |
| extStart | output | 1 | Start readout of one bank |
| extBank | output | 3 | Bank to read out |
| busy | output | 1 | Every bank is occupied; triggers are being dropped |
| dropCount | output | 16 | Saturating count of dropped triggers |

## Verification
The hardest situation to reach is a full ring that recovers. All eight banks must be occupied while triggers keep arriving, and then the ring must refill in the right order as banks drain one by one. The stimulus gets there with a directed fill that never completes a conversion. It then runs random phases whose trigger rates are high and whose completion rates are low, so the ring saturates, followed by phases with the rates reversed so it drains. Throughout, a cycle-by-cycle bench model predicts each bank state, the start strobes, the freeze order and the drop count.

// File: rtl/evt_bank_sched_pkg.sv
package evt_bank_sched_pkg;

  typedef enum logic [2:0] {
    BK_FREE    = 3'd0,
    BK_SAMPLE  = 3'd1,
    BK_FROZEN  = 3'd2,
    BK_CONV    = 3'd3,
    BK_READY   = 3'd4,
    BK_EXTRACT = 3'd5
  } bank_st_e;

  // control -> datapath strobes, all valid for a single cycle
  typedef struct packed {
    logic freeze;      // sampling bank stops at this window end
    logic claim;       // a free bank becomes the sampling bank
    logic startConv;   // all frozen banks enter conversion
    logic finishConv;  // all converting banks become ready
    logic startExt;    // head of freeze order enters readout
    logic finishExt;   // extracting bank is released
    logic drop;        // trigger lost while every bank is occupied
  } strobe_t;

endpackage

// File: rtl/bank_sched_ctrl.sv
module bank_sched_ctrl
  import evt_bank_sched_pkg::*;
#(
  parameter int NB = 8,
  parameter int BW = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          trig,
  input  logic          windowEnd,
  input  logic          convDone,
  input  logic          extDone,
  input  logic [NB-1:0] freeVec,
  input  logic [NB-1:0] frozenVec,
  input  logic [BW-1:0] capPtr,
  input  logic          headReady,
  input  logic          fifoEmpty,
  output strobe_t       stb,
  output logic [BW-1:0] claimIdx,
  output logic          busy
);

  logic pending;
  logic convActive;
  logic extActive;
  logic found;

  // round-robin search: nearest free bank after capPtr, capPtr itself last
  always_comb begin
    found    = 1'b0;
    claimIdx = '0;
    for (int k = NB; k >= 1; k--) begin
      if (freeVec[(int'(capPtr) + k) % NB]) begin
        found    = 1'b1;
        claimIdx = BW'((int'(capPtr) + k) % NB);
      end
    end
  end

  always_comb begin
    stb            = '0;
    stb.freeze     = windowEnd && (pending || trig) && !busy;
    stb.claim      = found && (stb.freeze || busy);
    stb.drop       = trig && busy;
    stb.startConv  = !convActive && (|frozenVec);
    stb.finishConv = convActive && convDone;
    stb.startExt   = !extActive && !fifoEmpty && headReady;
    stb.finishExt  = extActive && extDone;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending    <= 1'b0;
      busy       <= 1'b0;
      convActive <= 1'b0;
      extActive  <= 1'b0;
    end else begin
      if (stb.freeze)        pending <= 1'b0;
      else if (trig && !busy) pending <= 1'b1;

      if (stb.freeze && !found) busy <= 1'b1;
      else if (busy && found)   busy <= 1'b0;

      if (stb.startConv)       convActive <= 1'b1;
      else if (stb.finishConv) convActive <= 1'b0;

      if (stb.startExt)        extActive <= 1'b1;
      else if (stb.finishExt)  extActive <= 1'b0;
    end
  end

endmodule

// File: rtl/bank_sched_dp.sv
module bank_sched_dp
  import evt_bank_sched_pkg::*;
#(
  parameter int NB = 8,
  parameter int BW = 3,
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         stb,
  input  logic [BW-1:0]   claimIdx,
  output logic [NB-1:0]   freeVec,
  output logic [NB-1:0]   frozenVec,
  output logic [BW-1:0]   capPtr,
  output logic [BW-1:0]   headIdx,
  output logic            headReady,
  output logic            fifoEmpty,
  output logic [3*NB-1:0] bankStateFlat,
  output logic [DW-1:0]   dropCount
);

  logic [NB-1:0] readyVec;
  logic [BW-1:0] order [NB];
  logic [BW-1:0] wrPtr, rdPtr;
  logic [BW:0]   fillCnt;

  function automatic logic [BW-1:0] bump(input logic [BW-1:0] p);
    return (int'(p) == NB - 1) ? '0 : p + 1'b1;
  endfunction

  for (genvar i = 0; i < NB; i++) begin : g_bank
    bank_st_e st;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                        st <= (i == 0) ? BK_SAMPLE : BK_FREE;
      else if (stb.finishExt && st == BK_EXTRACT)       st <= BK_FREE;
      else if (stb.finishConv && st == BK_CONV)         st <= BK_READY;
      else if (stb.startConv && st == BK_FROZEN)        st <= BK_CONV;
      else if (stb.startExt && headIdx == BW'(i))       st <= BK_EXTRACT;
      else if (stb.freeze && capPtr == BW'(i))          st <= BK_FROZEN;
      else if (stb.claim && claimIdx == BW'(i))         st <= BK_SAMPLE;
    end
    assign freeVec[i]             = (st == BK_FREE);
    assign frozenVec[i]           = (st == BK_FROZEN);
    assign readyVec[i]            = (st == BK_READY);
    assign bankStateFlat[3*i +: 3] = st;
  end

  // freeze order queue: readout follows it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      fillCnt <= '0;
      for (int j = 0; j < NB; j++) order[j] <= '0;
    end else begin
      if (stb.freeze) begin
        order[wrPtr] <= capPtr;
        wrPtr        <= bump(wrPtr);
      end
      if (stb.startExt) rdPtr <= bump(rdPtr);
      if (stb.freeze && !stb.startExt)      fillCnt <= fillCnt + 1'b1;
      else if (!stb.freeze && stb.startExt) fillCnt <= fillCnt - 1'b1;
    end
  end

  assign headIdx   = order[rdPtr];
  assign fifoEmpty = (fillCnt == '0);
  assign headReady = readyVec[headIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capPtr    <= '0;
      dropCount <= '0;
    end else begin
      if (stb.claim) capPtr <= claimIdx;
      if (stb.drop && dropCount != {DW{1'b1}}) dropCount <= dropCount + 1'b1;
    end
  end

endmodule

// File: rtl/evt_bank_sched.sv
module evt_bank_sched
  import evt_bank_sched_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int DROP_W    = 16,
  localparam int BW       = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   selfTrig,
  input  logic                   extTrig,
  input  logic                   windowEnd,
  input  logic                   convDone,
  input  logic                   extDone,
  output logic [BW-1:0]          captureBank,
  output logic [3*NUM_BANKS-1:0] bankState,
  output logic                   convStart,
  output logic [NUM_BANKS-1:0]   convMask,
  output logic                   extStart,
  output logic [BW-1:0]          extBank,
  output logic                   busy,
  output logic [DROP_W-1:0]      dropCount
);

  strobe_t              stb;
  logic [BW-1:0]        claimIdx;
  logic [NUM_BANKS-1:0] freeVec, frozenVec;
  logic [BW-1:0]        capPtr, headIdx;
  logic                 headReady, fifoEmpty;

  bank_sched_ctrl #(.NB(NUM_BANKS), .BW(BW)) u_ctrl (
    .clk(clk), .rstN(rstN), .trig(selfTrig | extTrig), .windowEnd(windowEnd),
    .convDone(convDone), .extDone(extDone), .freeVec(freeVec), .frozenVec(frozenVec),
    .capPtr(capPtr), .headReady(headReady), .fifoEmpty(fifoEmpty),
    .stb(stb), .claimIdx(claimIdx), .busy(busy)
  );

  bank_sched_dp #(.NB(NUM_BANKS), .BW(BW), .DW(DROP_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .claimIdx(claimIdx),
    .freeVec(freeVec), .frozenVec(frozenVec), .capPtr(capPtr), .headIdx(headIdx),
    .headReady(headReady), .fifoEmpty(fifoEmpty), .bankStateFlat(bankState),
    .dropCount(dropCount)
  );

  assign captureBank = capPtr;
  assign convStart   = stb.startConv;
  assign convMask    = frozenVec;
  assign extStart    = stb.startExt;
  assign extBank     = headIdx;

endmodule

// File: rtl/evt_bank_sched_chk.sv
module evt_bank_sched_chk #(
  parameter int NB = 8,
  parameter int BW = 3,
  parameter int DW = 16
) (
  input logic            clk,
  input logic            rstN,
  input logic            windowEnd,
  input logic [BW-1:0]   captureBank,
  input logic [3*NB-1:0] bankState,
  input logic            convStart,
  input logic            extStart,
  input logic [BW-1:0]   extBank,
  input logic            busy,
  input logic [DW-1:0]   dropCount
);

  logic [NB-1:0] sampleVec;
  logic [BW-1:0] prevExtBank;

  for (genvar i = 0; i < NB; i++) begin : g_s
    assign sampleVec[i] = (bankState[3*i +: 3] == 3'd1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevExtBank <= '0;
    else       prevExtBank <= extBank;
  end

  // R4
  one_sampler_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> ($countones(sampleVec) == 1 && sampleVec[captureBank]));

  // R9
  no_sampler_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (sampleVec == '0));

  // R2
  hold_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !windowEnd) |=> $stable(captureBank));

  // R5
  conv_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);

  // R7
  ext_launch_chk: assert property (@(posedge clk) disable iff (!rstN)
    extStart |=> (bankState[3*prevExtBank +: 3] == 3'd5));

  // R9
  drop_mono_chk: assert property (@(posedge clk) disable iff (!rstN)
    dropCount >= $past(dropCount));

endmodule

bind evt_bank_sched evt_bank_sched_chk #(.NB(NUM_BANKS), .BW(BW), .DW(DROP_W)) u_chk (
  .clk(clk), .rstN(rstN), .windowEnd(windowEnd), .captureBank(captureBank),
  .bankState(bankState), .convStart(convStart), .extStart(extStart),
  .extBank(extBank), .busy(busy), .dropCount(dropCount)
);

// File: tb/sim_evt_bank_sched.sv
module sim_evt_bank_sched;
  localparam int NB = 8;
  localparam int BW = 3;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic selfTrig = 1'b0, extTrig = 1'b0, windowEnd = 1'b0, convDone = 1'b0, extDone = 1'b0;
  logic [BW-1:0]   captureBank, extBank;
  logic [3*NB-1:0] bankState;
  logic [NB-1:0]   convMask;
  logic            convStart, extStart, busy;
  logic [DW-1:0]   dropCount;

  always #10 clk = ~clk;

  evt_bank_sched #(.NUM_BANKS(NB), .DROP_W(DW)) u0 (
    .clk(clk), .rstN(rstN), .selfTrig(selfTrig), .extTrig(extTrig), .windowEnd(windowEnd),
    .convDone(convDone), .extDone(extDone), .captureBank(captureBank), .bankState(bankState),
    .convStart(convStart), .convMask(convMask), .extStart(extStart), .extBank(extBank),
    .busy(busy), .dropCount(dropCount)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  int mSt[NB];
  int mCap, mDrop, mRd, mWr, mCnt;
  int mFifo[NB];
  bit mPend, mBusy, mConv, mExt;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void modelReset();
    for (int i = 0; i < NB; i++) begin mSt[i] = (i == 0) ? 1 : 0; mFifo[i] = 0; end
    mCap = 0; mDrop = 0; mRd = 0; mWr = 0; mCnt = 0;
    mPend = 0; mBusy = 0; mConv = 0; mExt = 0;
  endfunction

  function automatic bit expConv();
    bit any = 0;
    for (int i = 0; i < NB; i++) if (mSt[i] == 2) any = 1;
    return !mConv && any;
  endfunction

  function automatic bit expExt();
    return !mExt && mCnt > 0 && mSt[mFifo[mRd]] == 4;
  endfunction

  function automatic void modelStep(input bit trig, input bit we, input bit cd, input bit ed);
    int ns[NB];
    int idx = 0;
    bit found = 0;
    bit frz, clm, sc, fc, se, fe;
    for (int k = 1; k <= NB; k++)
      if (!found && mSt[(mCap + k) % NB] == 0) begin found = 1; idx = (mCap + k) % NB; end
    frz = we && (mPend || trig) && !mBusy;
    clm = found && (frz || mBusy);
    sc  = expConv();
    fc  = mConv && cd;
    se  = expExt();
    fe  = mExt && ed;
    for (int i = 0; i < NB; i++) begin
      ns[i] = mSt[i];
      if (fe && mSt[i] == 5) ns[i] = 0;
      if (fc && mSt[i] == 3) ns[i] = 4;
      if (sc && mSt[i] == 2) ns[i] = 3;
      if (se && i == mFifo[mRd]) ns[i] = 5;
      if (frz && i == mCap) ns[i] = 2;
      if (clm && i == idx) ns[i] = 1;
    end
    if (trig && mBusy && mDrop < 65535) mDrop++;
    if (se) begin mRd = (mRd + 1) % NB; mCnt--; end
    if (frz) begin mFifo[mWr] = mCap; mWr = (mWr + 1) % NB; mCnt++; end
    if (frz) mPend = 0; else if (trig && !mBusy) mPend = 1;
    if (frz && !found) mBusy = 1; else if (mBusy && found) mBusy = 0;
    if (sc) mConv = 1; else if (fc) mConv = 0;
    if (se) mExt = 1; else if (fe) mExt = 0;
    if (clm) mCap = idx;
    for (int i = 0; i < NB; i++) mSt[i] = ns[i];
  endfunction

  task automatic checkAll();
    int mask = 0;
    for (int i = 0; i < NB; i++) if (mSt[i] == 2) mask |= (1 << i);
    chk("R4 captureBank", captureBank, mCap);
    for (int i = 0; i < NB; i++) chk("R6 bankState", bankState[3*i +: 3], mSt[i]);
    chk("R5 convStart", convStart, expConv());
    chk("R5 convMask", convMask, mask);
    chk("R7 extStart", extStart, expExt());
    if (mCnt > 0) chk("R7 extBank", extBank, mFifo[mRd]);
    chk("R9 busy", busy, mBusy);
    chk("R9 dropCount", dropCount, mDrop);
  endtask

  task automatic cyc(input bit st, input bit et, input bit we, input bit cd, input bit ed);
    @(negedge clk);
    checkAll();
    selfTrig = st; extTrig = et; windowEnd = we; convDone = cd; extDone = ed;
    modelStep(st | et, we, cd, ed);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0; selfTrig = 0; extTrig = 0; windowEnd = 0; convDone = 0; extDone = 0;
    modelReset();
    repeat (2) @(negedge clk);
    rstN = 1;
    modelStep(0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20251006));
    doReset();
    // R1 reset state, then idle done strobes are ignored (R6, R8)
    cyc(0, 0, 0, 1, 1);
    chk("R1 reset bankState", bankState, 24'd1);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset dropCount", dropCount, 0);
    chk("R1 reset strobes", {convStart, extStart}, 0);
    cyc(0, 0, 0, 0, 0);
    chk("R6 idle convDone ignored", bankState, 24'd1);
    chk("R8 idle extDone ignored", captureBank, 0);
    // R3 merged triggers, freeze only at window end (R2)
    cyc(1, 0, 0, 0, 0);
    cyc(0, 1, 0, 0, 0);
    chk("R2 trigger alone keeps sampling", bankState[2:0], 1);
    cyc(1, 0, 0, 0, 0);
    cyc(0, 0, 1, 0, 0);
    chk("R2 no freeze before window end", bankState[2:0], 1);
    cyc(0, 0, 0, 0, 0);
    chk("R3 one freeze captureBank", captureBank, 1);
    chk("R3 bank0 frozen", bankState[2:0], 2);
    chk("R3 bank1 sampling", bankState[5:3], 1);
    cyc(0, 0, 1, 0, 0);
    chk("R5 bank0 converting", bankState[2:0], 3);
    cyc(0, 0, 0, 1, 0);
    chk("R2 merged trigger gone", captureBank, 1);
    cyc(0, 0, 0, 0, 0);
    chk("R6 bank0 converted", bankState[2:0], 4);
    chk("R7 extStart", extStart, 1);
    chk("R7 extBank", extBank, 0);
    cyc(0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0);
    chk("R8 bank0 freed", bankState[2:0], 0);

    // R10 fill the ring without completions
    doReset();
    for (int k = 0; k < NB; k++) begin
      cyc(1, 0, 1, 0, 0);
      if (k == NB - 1) chk("R10 busy low after seven freezes", busy, 0);
    end
    cyc(0, 1, 0, 0, 0);
    chk("R10 busy after eighth freeze", busy, 1);
    cyc(1, 0, 1, 0, 0);
    cyc(0, 0, 0, 0, 0);
    chk("R9 dropped triggers", dropCount, 2);

    // random phases: balanced, saturating, draining, mixed
    for (int p = 0; p < 4; p++) begin
      int tp, wp, cp, ep;
      case (p)
        0: begin tp = 20; wp = 30; cp = 40; ep = 40; end
        1: begin tp = 60; wp = 50; cp = 5;  ep = 5;  end
        2: begin tp = 10; wp = 20; cp = 80; ep = 80; end
        default: begin tp = 50; wp = 25; cp = 25; ep = 30; end
      endcase
      for (int n = 0; n < 2500; n++) begin
        bit t;
        bit src;
        t   = ($urandom_range(99) < tp);
        src = $urandom_range(1);
        cyc(t && src, t && !src, $urandom_range(99) < wp,
            $urandom_range(99) < cp, $urandom_range(99) < ep);
      end
    end
    cyc(0, 0, 0, 0, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule